// File: doc/BRIEF.md
# Inner Stack Pointer Locator

This sequential unit serves an inter-privilege call through a gate. Given the kind of gate (16-bit, 32-bit, or a 64-bit gate in long mode), the privilege level of the target code segment and the base and limit of the task state segment, it works out where the privileged stack pointer and stack selector for that level are stored. It checks that slot against the segment limit, fetches it with one request on a simple read port, and unpacks the new stack pointer and stack selector.

Outside long mode the new stack selector is then validated in a fixed order. A null selector is rejected first. The unit then asks for the decoded descriptor of the selector and checks privilege agreement, then the segment type, then presence. In long mode the stack selector is not read from memory: it is a null selector carrying the target level as its RPL, and no descriptor is requested. The result is either a completion pulse with the new pointer and selector, or a fault pulse with a fault kind and the selector to report.

Top module: `istk_locator`

## Requirements
- R1: With long_mode=0 and gate_wide=0 (16-bit gate), the read goes to tss_base + 2 + 4×tgt_dpl for 4 bytes; new_sp is bytes 0–1 of rd_rdata (rd_rdata[15:0], zero-extended) and new_ss is rd_rdata[31:16].
- R2: With long_mode=0 and gate_wide=1 (32-bit gate), the read goes to tss_base + 4 + 8×tgt_dpl for 6 bytes; new_sp is rd_rdata[31:0], zero-extended, and new_ss is rd_rdata[47:32].
- R3: With long_mode=1, the read goes to tss_base + 4 + 8×tgt_dpl for 8 bytes. new_sp is all 64 bits of rd_rdata, and new_ss equals tgt_dpl (index zero). No descriptor is requested and the unit completes with done.
- R4: If (slot offset + byte count − 1), taken to 16 bits, exceeds tss_limit, the unit faults with fault_kind=1 (invalid TSS) and fault_sel=tss_sel, and it issues no read. A last byte equal to the limit is accepted.
- R5: Outside long mode, a new selector whose bits [15:2] are zero faults with fault_kind=1 and fault_sel set to that selector, and no descriptor is requested.
- R6: Outside long mode, if tgt_dpl differs from the new selector's RPL (bits [1:0]) or from desc_dpl, the unit faults with fault_kind=1 and fault_sel=new selector.
- R7: Once R6 passes, a descriptor with desc_code=1 or desc_write=0 faults with fault_kind=1 and fault_sel=new selector.
- R8: Once R7 passes, desc_present=0 faults with fault_kind=2 (stack fault) and fault_sel=new selector. A descriptor that fails both type and presence reports kind 1.
- R9: busy rises after an accepted start and stays high until the cycle done or fault pulses. start is ignored while busy, and all operands are captured at start. rd_valid stays high, with rd_addr and rd_bytes stable, until rd_ready.
- R10: done and fault are one-cycle pulses and never high together. desc_sel carries the new selector while desc_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (taken when idle) |
| long_mode | input | 1 | Long-mode flag, selects the 64-bit layout |
| gate_wide | input | 1 | 1 = 32-bit gate, 0 = 16-bit gate (outside long mode) |
| tgt_dpl | input | 2 | Privilege level of the target code segment |
| tss_base | input | AW | Linear base of the task state segment |
| tss_limit | input | LW | Limit of the task state segment |
| tss_sel | input | 16 | Selector of the task state segment, for faults |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rd_bytes | output | 4 | Number of bytes requested |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 64 | Read data, byte 0 in bits [7:0] |
| desc_req | output | 1 | Request for the new selector's decoded descriptor |
| desc_sel | output | 16 | Selector whose descriptor is requested |
| desc_vld | input | 1 | Descriptor fields valid |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_code | input | 1 | Descriptor is a code segment |
| desc_write | input | 1 | Descriptor is writable |
| desc_present | input | 1 | Descriptor present |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | Success pulse |
| fault | output | 1 | Fault pulse |
| fault_kind | output | 2 | 1 = invalid TSS, 2 = stack fault |
| fault_sel | output | 16 | Selector reported with the fault |
| new_sp | output | 64 | New stack pointer |
| new_ss | output | 16 | New stack selector |

## Verification
The assertions assume the environment keeps its side of both handshakes. rd_rvalid and desc_vld pulse only after the matching request has been accepted. The descriptor fields are valid in the cycle desc_vld is high. The stimulus keeps to this by answering each request once, in the cycle after it sees it, and by holding start low from the cycle after its pulse until the result. The one exception is a deliberate pulse of start during a lookup. The random cases steer the limit to within one byte of the slot end, and they bias the selector and descriptor fields so that every branch of the check order is reached.

// File: rtl/istk_pkg.sv
package istk_pkg;

  typedef enum logic [1:0] {
    GK_16 = 2'd0,
    GK_32 = 2'd1,
    GK_64 = 2'd2
  } gate_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TSS   = 2'd1,
    FLT_STACK = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LIMIT,
    S_REQ,
    S_WAIT,
    S_EVAL,
    S_DESC
  } state_e;

  // Byte offset of the stack slot for a privilege level.
  function automatic logic [15:0] slot_offset(gate_kind_e kind, logic [1:0] dpl,
                                              int ofs16, int ofs32, int ofs64);
    logic [15:0] o;
    case (kind)
      GK_16:   o = 16'(ofs16) + {12'd0, dpl, 2'b00};
      GK_32:   o = 16'(ofs32) + {11'd0, dpl, 3'b000};
      default: o = 16'(ofs64) + {11'd0, dpl, 3'b000};
    endcase
    return o;
  endfunction

  // Number of bytes occupied by the slot.
  function automatic logic [3:0] slot_bytes(gate_kind_e kind);
    case (kind)
      GK_16:   return 4'd4;
      GK_32:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/istk_slot_calc.sv
module istk_slot_calc
  import istk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 32,
  parameter int OFS16 = 2,
  parameter int OFS32 = 4,
  parameter int OFS64 = 4
) (
  input  gate_kind_e    kind,
  input  logic [1:0]    dpl,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] limit,
  output logic [AW-1:0] addr,
  output logic [3:0]    nbytes,
  output logic          over
);
  localparam int CW = LW + 16;

  logic [15:0] off;
  logic [15:0] last;

  always_comb begin
    off    = slot_offset(kind, dpl, OFS16, OFS32, OFS64);
    nbytes = slot_bytes(kind);
    last   = off + {12'd0, nbytes} - 16'd1;
    addr   = base + AW'(off);
    over   = CW'(last) > CW'(limit);
  end

endmodule

// File: rtl/istk_unpack.sv
module istk_unpack
  import istk_pkg::*;
(
  input  gate_kind_e  kind,
  input  logic [1:0]  dpl,
  input  logic [63:0] data,
  output logic [63:0] sp,
  output logic [15:0] ss
);
  always_comb begin
    case (kind)
      GK_16: begin
        sp = {48'd0, data[15:0]};
        ss = data[31:16];
      end
      GK_32: begin
        sp = {32'd0, data[31:0]};
        ss = data[47:32];
      end
      default: begin
        sp = data;
        ss = {14'd0, dpl};
      end
    endcase
  end
endmodule

// File: rtl/istk_ss_check.sv
module istk_ss_check
  import istk_pkg::*;
(
  input  logic [15:0] ss,
  input  logic [1:0]  dpl,
  input  logic [1:0]  d_dpl,
  input  logic        d_code,
  input  logic        d_write,
  input  logic        d_present,
  output logic        is_null,
  output fault_e      verdict
);
  logic priv_bad;
  logic type_bad;

  always_comb begin
    is_null  = (ss[15:2] == 14'd0);
    priv_bad = (ss[1:0] != dpl) || (d_dpl != dpl);
    type_bad = d_code || !d_write;
    if (priv_bad)        verdict = FLT_TSS;
    else if (type_bad)   verdict = FLT_TSS;
    else if (!d_present) verdict = FLT_STACK;
    else                 verdict = FLT_NONE;
  end
endmodule

// File: rtl/istk_locator.sv
module istk_locator
  import istk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 32,
  parameter int OFS16 = 2,
  parameter int OFS32 = 4,
  parameter int OFS64 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          long_mode,
  input  logic          gate_wide,
  input  logic [1:0]    tgt_dpl,
  input  logic [AW-1:0] tss_base,
  input  logic [LW-1:0] tss_limit,
  input  logic [15:0]   tss_sel,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [3:0]    rd_bytes,
  input  logic          rd_rvalid,
  input  logic [63:0]   rd_rdata,
  output logic          desc_req,
  output logic [15:0]   desc_sel,
  input  logic          desc_vld,
  input  logic [1:0]    desc_dpl,
  input  logic          desc_code,
  input  logic          desc_write,
  input  logic          desc_present,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_kind,
  output logic [15:0]   fault_sel,
  output logic [63:0]   new_sp,
  output logic [15:0]   new_ss
);

  state_e        state;
  gate_kind_e    kind_q;
  logic [1:0]    dpl_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] lim_q;
  logic [15:0]   tsel_q;
  logic [63:0]   sp_q;
  logic [15:0]   ss_q;
  fault_e        fkind_q;

  // Named internal events
  logic          lim_over;
  logic [AW-1:0] slot_addr;
  logic [3:0]    slot_nb;
  logic [63:0]   unpk_sp;
  logic [15:0]   unpk_ss;
  logic          ss_null;
  fault_e        chk_verdict;
  logic          req_fire;
  logic          rsp_take;
  gate_kind_e    start_kind;

  istk_slot_calc #(
    .AW(AW), .LW(LW), .OFS16(OFS16), .OFS32(OFS32), .OFS64(OFS64)
  ) u_slot (
    .kind(kind_q), .dpl(dpl_q), .base(base_q), .limit(lim_q),
    .addr(slot_addr), .nbytes(slot_nb), .over(lim_over)
  );

  istk_unpack u_unpack (
    .kind(kind_q), .dpl(dpl_q), .data(rd_rdata),
    .sp(unpk_sp), .ss(unpk_ss)
  );

  istk_ss_check u_check (
    .ss(ss_q), .dpl(dpl_q), .d_dpl(desc_dpl), .d_code(desc_code),
    .d_write(desc_write), .d_present(desc_present),
    .is_null(ss_null), .verdict(chk_verdict)
  );

  always_comb begin
    if (long_mode)      start_kind = GK_64;
    else if (gate_wide) start_kind = GK_32;
    else                start_kind = GK_16;
  end

  assign rd_valid   = (state == S_REQ);
  assign rd_addr    = slot_addr;
  assign rd_bytes   = slot_nb;
  assign req_fire   = rd_valid && rd_ready;
  assign rsp_take   = (state == S_WAIT) && rd_rvalid;
  assign desc_req   = (state == S_DESC);
  assign desc_sel   = ss_q;
  assign busy       = (state != S_IDLE);
  assign fault_kind = fkind_q;
  assign new_sp     = sp_q;
  assign new_ss     = ss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind_q    <= GK_16;
      dpl_q     <= 2'd0;
      base_q    <= '0;
      lim_q     <= '0;
      tsel_q    <= 16'd0;
      sp_q      <= 64'd0;
      ss_q      <= 16'd0;
      fkind_q   <= FLT_NONE;
      fault_sel <= 16'd0;
      done      <= 1'b0;
      fault     <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            kind_q <= start_kind;
            dpl_q  <= tgt_dpl;
            base_q <= tss_base;
            lim_q  <= tss_limit;
            tsel_q <= tss_sel;
            state  <= S_LIMIT;
          end
        end
        S_LIMIT: begin
          if (lim_over) begin
            fault     <= 1'b1;
            fkind_q   <= FLT_TSS;
            fault_sel <= tsel_q;
            state     <= S_IDLE;
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ: begin
          if (req_fire) state <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_take) begin
            sp_q  <= unpk_sp;
            ss_q  <= unpk_ss;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (kind_q == GK_64) begin
            done    <= 1'b1;
            fkind_q <= FLT_NONE;
            state   <= S_IDLE;
          end else if (ss_null) begin
            fault     <= 1'b1;
            fkind_q   <= FLT_TSS;
            fault_sel <= ss_q;
            state     <= S_IDLE;
          end else begin
            state <= S_DESC;
          end
        end
        S_DESC: begin
          if (desc_vld) begin
            if (chk_verdict == FLT_NONE) begin
              done    <= 1'b1;
              fkind_q <= FLT_NONE;
            end else begin
              fault     <= 1'b1;
              fkind_q   <= chk_verdict;
              fault_sel <= ss_q;
            end
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Assertions
  AST_NO_READ_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !lim_over); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_bytes))); // R9

  AST_BUSY_ENDS_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fault)); // R9

  AST_LONG_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req |-> (kind_q != GK_64)); // R3

  AST_NULL_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req |-> !ss_null); // R5

  AST_STACK_AFTER_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_kind == FLT_STACK) |->
      (!$past(desc_present) && $past(desc_write) && !$past(desc_code))); // R8

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault)); // R10

endmodule

// File: tb/istk_locator_bench.sv
`timescale 1ns/1ps
module istk_locator_bench;

  localparam int AW = 32;
  localparam int LW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          long_mode = 1'b0;
  logic          gate_wide = 1'b0;
  logic [1:0]    tgt_dpl = 2'd0;
  logic [AW-1:0] tss_base = '0;
  logic [LW-1:0] tss_limit = '0;
  logic [15:0]   tss_sel = 16'd0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [3:0]    rd_bytes;
  logic          rd_rvalid = 1'b0;
  logic [63:0]   rd_rdata = 64'd0;
  logic          desc_req;
  logic [15:0]   desc_sel;
  logic          desc_vld = 1'b0;
  logic [1:0]    desc_dpl = 2'd0;
  logic          desc_code = 1'b0;
  logic          desc_write = 1'b0;
  logic          desc_present = 1'b0;
  logic          busy, done, fault;
  logic [1:0]    fault_kind;
  logic [15:0]   fault_sel;
  logic [63:0]   new_sp;
  logic [15:0]   new_ss;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  istk_locator #(.AW(AW), .LW(LW)) u_istk_locator (
    .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode),
    .gate_wide(gate_wide), .tgt_dpl(tgt_dpl), .tss_base(tss_base),
    .tss_limit(tss_limit), .tss_sel(tss_sel), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .desc_req(desc_req),
    .desc_sel(desc_sel), .desc_vld(desc_vld), .desc_dpl(desc_dpl),
    .desc_code(desc_code), .desc_write(desc_write),
    .desc_present(desc_present), .busy(busy), .done(done), .fault(fault),
    .fault_kind(fault_kind), .fault_sel(fault_sel), .new_sp(new_sp),
    .new_ss(new_ss)
  );

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench-side restatement of the slot layout
  function automatic int exp_off(bit lm, bit wide, logic [1:0] dpl);
    if (lm)   return 4 + 8 * int'(dpl);
    if (wide) return 4 + 8 * int'(dpl);
    return 2 + 4 * int'(dpl);
  endfunction

  function automatic int exp_nb(bit lm, bit wide);
    return lm ? 8 : (wide ? 6 : 4);
  endfunction

  function automatic string mode_req(bit lm, bit wide);
    return lm ? "R3" : (wide ? "R2" : "R1");
  endfunction

  // result codes: 0 done, 1 invalid TSS, 2 stack fault
  task automatic run_case(bit lm, bit wide, logic [1:0] dpl, logic [31:0] base,
                          logic [31:0] lim, logic [15:0] tsel, logic [63:0] word,
                          logic [1:0] ddpl, bit dcode, bit dwr, bit dpres, bit poke);
    int          off = exp_off(lm, wide, dpl);
    int          nb  = exp_nb(lm, wide);
    bit          over = (32'(off + nb - 1) > lim);
    logic [63:0] sp_e;
    logic [15:0] ss_e;
    int          res_e;
    logic [15:0] sel_e;
    bit          want_desc;
    bit          saw_rd = 0, saw_desc = 0, busy_bad = 0, ready_prev = 0, fin = 0;
    string       mr = mode_req(lm, wide);

    if (lm) begin
      sp_e = word; ss_e = {14'd0, dpl};
    end else if (wide) begin
      sp_e = {32'd0, word[31:0]}; ss_e = word[47:32];
    end else begin
      sp_e = {48'd0, word[15:0]}; ss_e = word[31:16];
    end
    want_desc = 0;
    sel_e = ss_e;
    if (over) begin res_e = 1; sel_e = tsel; end
    else if (lm) res_e = 0;
    else if (ss_e[15:2] == 14'd0) res_e = 1;
    else begin
      want_desc = 1;
      if (ss_e[1:0] != dpl || ddpl != dpl) res_e = 1;
      else if (dcode || !dwr)             res_e = 1;
      else if (!dpres)                    res_e = 2;
      else                                res_e = 0;
    end

    @(negedge clk);
    long_mode = lm; gate_wide = wide; tgt_dpl = dpl;
    tss_base = base; tss_limit = lim; tss_sel = tsel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // operands captured at start: disturb them now
    tgt_dpl = ~dpl; tss_base = $urandom; tss_limit = 32'd0;
    long_mode = ~lm; gate_wide = ~wide;

    for (int c = 0; c < 80; c++) begin
      if (poke && c == 1) start = 1'b1;
      if (poke && c == 2) start = 1'b0;
      if (done || fault) begin fin = 1; break; end
      if (!busy) busy_bad = 1;
      if (rd_rvalid) rd_rvalid = 1'b0;
      if (ready_prev) begin
        rd_ready = 1'b0; rd_rvalid = 1'b1; rd_rdata = word; ready_prev = 0;
      end else if (rd_valid) begin
        if (!saw_rd) begin
          chk(rd_addr == base + 32'(off), mr, "read address", 64'(rd_addr), 64'(base + 32'(off)));
          chk(rd_bytes == 4'(nb), mr, "read size", 64'(rd_bytes), 64'(nb));
        end
        saw_rd = 1;
        rd_ready = 1'($urandom % 2);
        ready_prev = rd_ready;
      end
      if (desc_vld) desc_vld = 1'b0;
      else if (desc_req) begin
        if (!saw_desc)
          chk(desc_sel == ss_e, "R10", "descriptor selector", 64'(desc_sel), 64'(ss_e));
        saw_desc = 1;
        desc_vld = 1'b1; desc_dpl = ddpl; desc_code = dcode;
        desc_write = dwr; desc_present = dpres;
      end
      @(negedge clk);
    end
    start = 1'b0; rd_ready = 1'b0; rd_rvalid = 1'b0; desc_vld = 1'b0;

    chk(fin, "R9", "lookup finished", 64'(fin), 64'd1);
    chk(!busy_bad, "R9", "busy held until result", 64'(busy_bad), 64'd0);
    chk(!(done && fault), "R10", "done and fault together", {done, fault}, 64'd0);
    chk(saw_rd == !over, "R4", "read issued", 64'(saw_rd), 64'(!over));
    chk(saw_desc == want_desc, lm ? "R3" : "R5", "descriptor requested", 64'(saw_desc), 64'(want_desc));
    if (res_e == 0) begin
      chk(done && !fault, mr, "completion", {done, fault}, 64'b10);
      chk(new_sp == sp_e, mr, "new_sp", new_sp, sp_e);
      chk(new_ss == ss_e, mr, "new_ss", 64'(new_ss), 64'(ss_e));
    end else begin
      string rq;
      if (over) rq = "R4";
      else if (ss_e[15:2] == 14'd0) rq = "R5";
      else if (res_e == 2) rq = "R8";
      else if (ss_e[1:0] != dpl || ddpl != dpl) rq = "R6";
      else rq = "R7";
      chk(fault && !done, rq, "fault pulse", {done, fault}, 64'b01);
      chk(fault_kind == 2'(res_e), rq, "fault kind", 64'(fault_kind), 64'(res_e));
      chk(fault_sel == sel_e, rq, "fault selector", 64'(fault_sel), 64'(sel_e));
    end
    @(negedge clk);
    chk(!done && !fault && !busy, "R10", "pulse lasts one cycle", {busy, done, fault}, 64'd0);
  endtask

  function automatic logic [63:0] place_ss(bit wide, logic [63:0] w, logic [15:0] ss);
    logic [63:0] r = w;
    if (wide) r[47:32] = ss; else r[31:16] = ss;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b2c3d4e));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !rd_valid && !desc_req, "R9", "reset state",
        {busy, done, fault, rd_valid, desc_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    run_case(0, 0, 2'd1, 32'h1000, 32'h67, 16'h28, place_ss(0, 64'h1111_2222_3333_abcd, 16'h0031), 2'd1, 0, 1, 1, 0); // R1
    run_case(0, 1, 2'd2, 32'h2000, 32'h67, 16'h28, place_ss(1, 64'h5555_0000_89ab_cdef, 16'h0052), 2'd2, 0, 1, 1, 0); // R2
    run_case(1, 0, 2'd3, 32'h3000, 32'h67, 16'h30, 64'hfedc_ba98_7654_3210, 2'd0, 1, 0, 0, 0);                      // R3
    run_case(0, 1, 2'd1, 32'h4000, 32'd17, 16'h38, place_ss(1, 64'h0, 16'h0041), 2'd1, 0, 1, 1, 0);                  // R4 last byte == limit
    run_case(0, 1, 2'd1, 32'h4000, 32'd16, 16'h38, place_ss(1, 64'h0, 16'h0041), 2'd1, 0, 1, 1, 0);                  // R4 one past
    run_case(1, 0, 2'd3, 32'h4000, 32'd34, 16'h40, 64'h1, 2'd3, 0, 1, 1, 0);                                         // R4 long mode
    run_case(0, 0, 2'd2, 32'h5000, 32'hff, 16'h28, place_ss(0, 64'h0, 16'h0002), 2'd2, 0, 1, 1, 0);                  // R5
    run_case(0, 0, 2'd2, 32'h5000, 32'hff, 16'h28, place_ss(0, 64'h0, 16'h0071), 2'd2, 0, 1, 1, 0);                  // R6 rpl
    run_case(0, 1, 2'd2, 32'h5000, 32'hff, 16'h28, place_ss(1, 64'h0, 16'h0072), 2'd1, 0, 1, 1, 0);                  // R6 dpl
    run_case(0, 1, 2'd0, 32'h5000, 32'hff, 16'h28, place_ss(1, 64'h0, 16'h0070), 2'd0, 1, 1, 1, 0);                  // R7 code
    run_case(0, 0, 2'd0, 32'h5000, 32'hff, 16'h28, place_ss(0, 64'h0, 16'h0070), 2'd0, 0, 0, 1, 0);                  // R7 read-only
    run_case(0, 1, 2'd3, 32'h5000, 32'hff, 16'h28, place_ss(1, 64'h0, 16'h007b), 2'd3, 0, 1, 0, 0);                  // R8
    run_case(0, 1, 2'd3, 32'h5000, 32'hff, 16'h28, place_ss(1, 64'h0, 16'h007b), 2'd3, 1, 1, 0, 0);                  // R7 before R8
    run_case(0, 0, 2'd1, 32'h6000, 32'hff, 16'h28, place_ss(0, 64'h9, 16'h0019), 2'd1, 0, 1, 1, 1);                  // R9 start while busy

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      bit          lm = ($urandom % 4) == 0;
      bit          wide = 1'($urandom % 2);
      logic [1:0]  dpl = 2'($urandom);
      int          last = exp_off(lm, wide, dpl) + exp_nb(lm, wide) - 1;
      logic [31:0] lim;
      logic [15:0] ss;
      logic [63:0] w = {$urandom, $urandom};
      logic [1:0]  ddpl = (($urandom % 5) == 0) ? 2'($urandom) : dpl;
      case ($urandom % 4)
        0: lim = 32'(last - 1);
        1: lim = 32'(last);
        2: lim = $urandom;
        default: lim = $urandom % 64;
      endcase
      case ($urandom % 6)
        0: ss = {14'd0, 2'($urandom)};
        1: ss = {14'($urandom) | 14'd1, 2'($urandom)};
        default: ss = {14'($urandom) | 14'd1, dpl};
      endcase
      if (!lm) w = place_ss(wide, w, ss);
      run_case(lm, wide, dpl, $urandom, lim, 16'($urandom), w, ddpl,
               ($urandom % 7) == 0, ($urandom % 7) != 0, ($urandom % 7) != 0,
               ($urandom % 10) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule